// File: doc/BRIEF.md
# Multiplexed-Bus Asynchronous Memory Read Sequencer

This block performs single asynchronous reads from an external NOR flash or PSRAM that shares one bus for low address bits and data. A host asks for a read by raising a request with an address. The sequencer counts clock cycles from the moment it pulls chip select low, and each strobe falls and rises at a fixed cycle offset. Chip select, address latch and output enable are all active low.

Each access has three phases. In the address phase the low address bits go onto the shared bus and the address-latch strobe is pulsed. The address is then held on the bus for one more cycle, after which the bus is released for a turnaround cycle. In the read phase output enable is held low. The high address bits have dedicated lines and stay constant for the whole access. The sequencer samples the bus in the last read-strobe cycle and returns that word to the host with a one-cycle ready pulse.

All phase lengths are parameters. The defaults are a 7-cycle access, a 1-cycle address strobe, a 1-cycle address hold, and output enable starting at cycle 3 and lasting to the end.

Top module: `amux_rd_seq`

## Requirements
- R1: While reset is held, and in every idle cycle, mem_ce_n, mem_adv_n and mem_oe_n are 1, bus_drive is 0, bus_out is 0 and rsp_valid is 0.
- R2: Numbering the cycles of an access 0..6 from the first cycle with mem_ce_n low, mem_ce_n is low for exactly those 7 consecutive cycles.
- R3: mem_adv_n is low in cycle 0 only.
- R4: bus_drive is 1 in cycles 0 and 1 only. While it is 1, bus_out carries the requested address bits [BUS_W-1:0].
- R5: mem_oe_n is low in cycles 3 to 6 (4 cycles) and is never low while bus_drive is 1.
- R6: mem_ce_n and mem_oe_n both return to 1 on the same clock edge, the one that ends cycle 6.
- R7: From cycle 0 to cycle 6, mem_hi_addr equals the requested address bits [ADDR_W-1:BUS_W] and does not change.
- R8: In the cycle after cycle 6, rsp_valid is 1 for exactly one cycle. At that point rsp_data holds the value that bus_in had during cycle 6.
- R9: A request is accepted only in an idle cycle, and the access begins on the next cycle. A request raised during an access has no effect. A request present in the rsp_valid cycle starts the next access immediately.
- R10: A synchronous reset asserted in the middle of an access brings the block back to the idle state of R1 at the next edge. No rsp_valid pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rq_valid | input | 1 | Read request |
| rq_addr | input | ADDR_W | Read address |
| rsp_valid | output | 1 | One-cycle pulse when read data is valid |
| rsp_data | output | BUS_W | Captured read data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_adv_n | output | 1 | Address latch strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_hi_addr | output | ADDR_W-BUS_W | Upper address lines |
| bus_out | output | BUS_W | Value driven onto the shared bus |
| bus_drive | output | 1 | 1 when the sequencer drives the shared bus |
| bus_in | input | BUS_W | Value read from the shared bus |

## Verification
The timing assertions assume that reset is held for at least one cycle before the first access. They also assume that any chip-select run is either complete or cut short by reset, and they exempt the edge that follows a reset from their rise checks. The memory model in the bench drives bus_in only while output enable is low. It uses the address it latched on the address strobe, so bus_in is never driven against bus_drive. The bench runs every address of an 8-bit configuration back to back, mixes in requests raised during an access, and asserts reset in the middle of an access only while rq_valid is low.

// File: rtl/amux_rd_pkg.sv
package amux_rd_pkg;

    typedef struct packed {
        logic ce_n;
        logic adv_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    localparam strobe_t STB_IDLE = '{ce_n: 1'b1, adv_n: 1'b1, oe_n: 1'b1, drive: 1'b0};

    // Strobe levels for access cycle k (k counted from the chip-select fall).
    function automatic strobe_t stb_decode(
        input logic        act,
        input int unsigned k,
        input int unsigned adv_cyc,
        input int unsigned drv_cyc,
        input int unsigned oe_dly
    );
        strobe_t s;
        s.ce_n  = !act;
        s.adv_n = !(act && (k < adv_cyc));
        s.drive = act && (k < drv_cyc);
        s.oe_n  = !(act && (k >= oe_dly));
        return s;
    endfunction

endpackage

// File: rtl/amux_phase_ctr.sv
module amux_phase_ctr #(
    parameter int CE_CYC = 7,
    localparam int CW = $clog2(CE_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rq_valid,
    output logic          busy_d,
    output logic [CW-1:0] cnt_d,
    output logic          start,
    output logic          last
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        start = !ctr_q.busy && rq_valid;
        last  = ctr_q.busy && (ctr_q.cnt == CW'(CE_CYC - 1));
        if (start) begin
            ctr_d.busy = 1'b1;
            ctr_d.cnt  = '0;
        end else if (last) begin
            ctr_d.busy = 1'b0;
            ctr_d.cnt  = '0;
        end else if (ctr_q.busy) begin
            ctr_d.cnt = ctr_q.cnt + 1'b1;
        end
        busy_d = ctr_d.busy;
        cnt_d  = ctr_d.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_q <= '0;
        else     ctr_q <= ctr_d;
    end
endmodule

// File: rtl/amux_capture.sv
module amux_capture #(
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic [BUS_W-1:0] bus_in,
    output logic             rsp_valid,
    output logic [BUS_W-1:0] rsp_data
);
    typedef struct packed {
        logic             vld;
        logic [BUS_W-1:0] dat;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = take;
        if (take) cap_d.dat = bus_in;
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign rsp_valid = cap_q.vld;
    assign rsp_data  = cap_q.dat;
endmodule

// File: rtl/amux_rd_seq.sv
module amux_rd_seq
    import amux_rd_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BUS_W     = 16,
    parameter int CE_CYC    = 7,
    parameter int ADV_CYC   = 1,
    parameter int ADDR_HOLD = 1,
    parameter int OE_DLY    = 3,
    localparam int HI_W     = ADDR_W - BUS_W,
    localparam int DRV_CYC  = ADV_CYC + ADDR_HOLD,
    localparam int CW       = $clog2(CE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rq_valid,
    input  logic [ADDR_W-1:0] rq_addr,
    output logic              rsp_valid,
    output logic [BUS_W-1:0]  rsp_data,
    output logic              mem_ce_n,
    output logic              mem_adv_n,
    output logic              mem_oe_n,
    output logic [HI_W-1:0]   mem_hi_addr,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_drive,
    input  logic [BUS_W-1:0]  bus_in
);
    typedef struct packed {
        strobe_t          stb;
        logic [BUS_W-1:0] lo;
        logic [HI_W-1:0]  hi;
    } seq_t;

    seq_t seq_d, seq_q;

    logic          busy_d;
    logic [CW-1:0] cnt_d;
    logic          start;
    logic          last;

    amux_phase_ctr #(.CE_CYC(CE_CYC)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .rq_valid (rq_valid),
        .busy_d   (busy_d),
        .cnt_d    (cnt_d),
        .start    (start),
        .last     (last)
    );

    amux_capture #(.BUS_W(BUS_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .take      (last),
        .bus_in    (bus_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    always_comb begin
        seq_d     = seq_q;
        seq_d.stb = stb_decode(busy_d, 32'(cnt_d), ADV_CYC, DRV_CYC, OE_DLY);
        if (start) begin
            seq_d.lo = rq_addr[BUS_W-1:0];
            seq_d.hi = rq_addr[ADDR_W-1:BUS_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q.stb <= STB_IDLE;
            seq_q.lo  <= '0;
            seq_q.hi  <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign mem_ce_n    = seq_q.stb.ce_n;
    assign mem_adv_n   = seq_q.stb.adv_n;
    assign mem_oe_n    = seq_q.stb.oe_n;
    assign bus_drive   = seq_q.stb.drive;
    assign bus_out     = seq_q.stb.drive ? seq_q.lo : '0;
    assign mem_hi_addr = seq_q.hi;
endmodule

// File: rtl/amux_rd_seq_chk.sv
module amux_rd_seq_chk #(
    parameter int CE_CYC    = 7,
    parameter int ADV_CYC   = 1,
    parameter int ADDR_HOLD = 1,
    parameter int OE_DLY    = 3,
    parameter int HI_W      = 8,
    localparam int CW       = $clog2(CE_CYC + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            mem_ce_n,
    input logic            mem_adv_n,
    input logic            mem_oe_n,
    input logic            bus_drive,
    input logic            rsp_valid,
    input logic [HI_W-1:0] mem_hi_addr
);
    logic [CW-1:0] lo_q;

    always_ff @(posedge clk) begin
        if (rst)            lo_q <= '0;
        else if (!mem_ce_n) lo_q <= lo_q + 1'b1;
        else                lo_q <= '0;
    end

    // R2
    ce_len_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> (lo_q < CW'(CE_CYC)));
    // R2
    ce_full_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_ce_n) && !$past(rst)) |-> ($past(lo_q) == CW'(CE_CYC - 1)));
    // R3
    adv_win_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> (mem_adv_n == (lo_q >= CW'(ADV_CYC))));
    // R1
    idle_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        mem_ce_n |-> (mem_adv_n && mem_oe_n && !bus_drive));
    // R4
    drive_win_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> (bus_drive == (lo_q < CW'(ADV_CYC + ADDR_HOLD))));
    // R5
    oe_win_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_ce_n |-> (mem_oe_n == (lo_q < CW'(OE_DLY))));
    // R5
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_drive && !mem_oe_n));
    // R6
    joint_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_ce_n) |-> $past(!mem_oe_n));
    // R7
    hi_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && lo_q != '0) |-> $stable(mem_hi_addr));
    // R8
    rsp_after_ce_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_ce_n) && !$past(rst)) |-> rsp_valid);
    // R8
    rsp_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $rose(mem_ce_n));
    // R8
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

bind amux_rd_seq amux_rd_seq_chk #(
    .CE_CYC    (CE_CYC),
    .ADV_CYC   (ADV_CYC),
    .ADDR_HOLD (ADDR_HOLD),
    .OE_DLY    (OE_DLY),
    .HI_W      (HI_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .mem_ce_n    (mem_ce_n),
    .mem_adv_n   (mem_adv_n),
    .mem_oe_n    (mem_oe_n),
    .bus_drive   (bus_drive),
    .rsp_valid   (rsp_valid),
    .mem_hi_addr (mem_hi_addr)
);

// File: tb/amux_rd_seq_test.sv
module amux_rd_seq_test;
    localparam int AW = 8;
    localparam int BW = 4;
    localparam int HW = AW - BW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          rq_valid = 1'b0;
    logic [AW-1:0] rq_addr = '0;
    logic          rsp_valid;
    logic [BW-1:0] rsp_data;
    logic          mem_ce_n, mem_adv_n, mem_oe_n, bus_drive;
    logic [HW-1:0] mem_hi_addr;
    logic [BW-1:0] bus_out;
    logic [BW-1:0] bus_in;
    logic [AW-1:0] dev_addr = '0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    amux_rd_seq #(.ADDR_W(AW), .BUS_W(BW)) uut (
        .clk         (clk),
        .rst         (rst),
        .rq_valid    (rq_valid),
        .rq_addr     (rq_addr),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .mem_ce_n    (mem_ce_n),
        .mem_adv_n   (mem_adv_n),
        .mem_oe_n    (mem_oe_n),
        .mem_hi_addr (mem_hi_addr),
        .bus_out     (bus_out),
        .bus_drive   (bus_drive),
        .bus_in      (bus_in)
    );

    function automatic logic [BW-1:0] fd(input logic [AW-1:0] a);
        return BW'(a * 5 + (a >> 4) + 1);
    endfunction

    // Memory model: latches the address on the strobe, answers under output enable.
    always @(posedge clk) if (!mem_adv_n && bus_drive) dev_addr <= {mem_hi_addr, bus_out};
    assign bus_in = !mem_oe_n ? fd(dev_addr) : '0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " ce_n"}, mem_ce_n, 1);
        chk({tag, " adv_n"}, mem_adv_n, 1);
        chk({tag, " oe_n"}, mem_oe_n, 1);
        chk({tag, " drive"}, bus_drive, 0);
        chk({tag, " bus_out"}, bus_out, 0);
        chk({tag, " rsp_valid"}, rsp_valid, 0);
    endtask

    // Called right after a negedge; returns right after the negedge of the ready cycle.
    task automatic do_read(input logic [AW-1:0] a, input bit intr);
        rq_valid = 1'b1;
        rq_addr  = a;
        @(negedge clk);
        rq_valid = 1'b0;
        rq_addr  = '0;
        chk("R2 ce_n c0", mem_ce_n, 0);
        chk("R3 adv_n c0", mem_adv_n, 0);
        chk("R4 drive c0", bus_drive, 1);
        chk("R4 bus_out c0", bus_out, a[BW-1:0]);
        chk("R7 hi c0", mem_hi_addr, a[AW-1:BW]);
        chk("R5 oe_n c0", mem_oe_n, 1);
        for (int k = 1; k < 7; k++) begin
            @(negedge clk);
            if (intr && k == 3) begin
                rq_valid = 1'b1;
                rq_addr  = ~a;
            end
            if (k == 4) rq_valid = 1'b0;
            chk("R2 ce_n", mem_ce_n, 0);
            chk("R3 adv_n", mem_adv_n, 1);
            chk("R4 drive", bus_drive, (k < 2) ? 1 : 0);
            if (k < 2) chk("R4 bus_out", bus_out, a[BW-1:0]);
            chk("R5 oe_n", mem_oe_n, (k >= 3) ? 0 : 1);
            chk("R7 hi", mem_hi_addr, a[AW-1:BW]);
        end
        @(negedge clk);
        chk("R6 ce_n rise", mem_ce_n, 1);
        chk("R6 oe_n rise", mem_oe_n, 1);
        chk("R8 rsp_valid", rsp_valid, 1);
        chk("R8 rsp_data", rsp_data, fd(a));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_idle("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1 after reset");
        // Full address sweep, back to back (R9 ready-cycle acceptance).
        for (int a = 0; a < (1 << AW); a++) begin
            do_read(AW'(a), (a % 17) == 5);
            if ((a % 17) == 5) begin
                @(negedge clk);
                chk("R9 ignored req, rsp one cycle", rsp_valid, 0);
                chk("R9 ignored req, no access", mem_ce_n, 1);
                @(negedge clk);
                chk("R9 ignored req, still idle", mem_ce_n, 1);
            end
        end
        @(negedge clk);
        chk("R8 single pulse", rsp_valid, 0);
        chk_idle("R1 idle gap");
        // Reset in the middle of an access.
        rq_valid = 1'b1;
        rq_addr  = 8'hA7;
        @(negedge clk);
        rq_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 mid access oe low", mem_oe_n, 0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_idle("R10 after abort");
        repeat (8) begin
            @(negedge clk);
            chk("R10 no late rsp", rsp_valid, 0);
            chk("R10 stays idle", mem_ce_n, 1);
        end
        do_read(8'h3C, 1'b0);
        @(negedge clk);
        chk_idle("R1 final idle");
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule